// File: doc/BRIEF.md
# Linked-Descriptor Scatter-Gather DMA Engine

This block is a multi-channel DMA sequencer that walks chains of descriptors held in a word-addressed memory. Every descriptor occupies five consecutive words:

| Word | Contents |
|------|----------|
| +0 | source byte address |
| +1 | destination byte address |
| +2 | byte count (low 16 bits) |
| +3 | control word (bit 0 enables the completion interrupt) |
| +4 | word address of the next descriptor (0 means end of chain) |

A single rotating visit pointer serves one channel per clock. On each visit a loaded channel issues one burst command of at most `BURST` bytes on the burst port. When a descriptor's count reaches zero, the engine optionally raises a completion pulse and then follows the link.

Software hands descriptors to a channel through the append port. It names the new descriptor and the current tail of that channel's chain. Depending on channel state, the engine takes one of three actions:

- it starts a stopped channel at the new descriptor;
- it writes the new descriptor into the channel's pending-link register;
- it patches the tail descriptor's link word in memory through the write port.

Per-channel fail and interrupt-miss counters let a test harness inject a channel error or suppress completion pulses. Both counters accept new values only while the channel is stopped.

Top module: `sgdma_engine`

## Requirements
- R1: After a synchronous reset every channel is stopped. No burst, completion pulse, error pulse, memory read or memory write is issued until an append arrives.
- R2: An append to a stopped channel sets its run flag (visible on `run_o` one cycle later). It stores the descriptor address as pending and marks no descriptor as loaded, so the next visit fetches it.
- R3: A descriptor fetch issues five memory reads on consecutive cycles, at word addresses base, base+1, …, base+4. Read data returns one cycle after each read. The fields are in the order source, destination, count, control, link.
- R4: A visit to a loaded channel with a nonzero count emits one burst of length min(count, `BURST`), default 0x800. It then advances source and destination by that length and subtracts it from the count. A zero count moves no bytes.
- R5: A visit that finds a loaded count of zero clears the loaded flag. If control bit 0 is set, it pulses that channel's `done_irq` bit, unless the miss counter is nonzero; in that case the counter is decremented and no pulse is issued.
- R6: In the same visit, a channel without a loaded descriptor starts a fetch if its pending link is nonzero. If the link is 0, the channel's run flag clears.
- R7: An append to a running channel with a zero pending link writes the pending link. Otherwise the engine writes the new address into memory word `app_last`+4.
- R8: An append to a running channel in the same cycle as the visit that would end its chain keeps the channel running, and the appended descriptor is transferred.
- R9: On each visit to a running channel with a nonzero fail counter, the counter decrements. The visit on which it goes from 1 to 0 clears run, pulses `err_irq` for that channel, and does nothing else.
- R10: Writes to the fail and miss counters of a running channel are ignored.
- R11: One channel is visited per cycle in rotating order, and visits pause while a fetch is in progress. A channel therefore never issues bursts less than `NCH` cycles apart, and at most one pulse of any kind appears per cycle.
- R12: A tail patch that targets the descriptor currently being fetched is applied to the link the fetch returns, even if the memory read of that link already happened.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| app_valid | input | 1 | append request strobe |
| app_chan | input | log2(NCH) | channel for the append |
| app_desc | input | PW | word address of the new descriptor |
| app_last | input | PW | word address of the chain's current tail descriptor |
| cfg_valid | input | 1 | counter write strobe |
| cfg_chan | input | log2(NCH) | channel for the counter write |
| cfg_fail | input | CW | fail countdown value (0 disables) |
| cfg_miss | input | CW | number of completion pulses to suppress |
| mem_rd_en | output | 1 | descriptor memory read strobe |
| mem_rd_addr | output | PW | descriptor memory read word address |
| mem_rd_data | input | 32 | read data, one cycle after the strobe |
| mem_wr_en | output | 1 | link patch write strobe |
| mem_wr_addr | output | PW | link patch word address |
| mem_wr_data | output | 32 | link patch data |
| bst_valid | output | 1 | burst command valid |
| bst_chan | output | log2(NCH) | channel issuing the burst |
| bst_src | output | 32 | burst source byte address |
| bst_dst | output | 32 | burst destination byte address |
| bst_len | output | 16 | burst length in bytes |
| done_irq | output | NCH | one-cycle completion pulse per channel |
| err_irq | output | NCH | one-cycle error pulse per channel |
| run_o | output | NCH | channel run flags |

## Verification
The assertions check the following on every cycle:

- every burst length is nonzero and within the cap;
- fetch reads advance one word at a time and never run longer than five;
- at most one completion or error pulse appears per cycle, and never alongside a burst;
- a channel that raises an error is already stopped.

The bench scenarios cover what needs whole transfers to show:

- byte totals and burst counts for a sweep of descriptor counts;
- chain following and termination;
- interrupt suppression;
- fail countdown timing;
- counter writes ignored while a channel runs;
- the three append paths;
- a sweep of append timings against a short chain, which hits the end-of-chain race and the in-flight fetch patch.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 16;
  localparam int NFIELD = 5;
  localparam int LINK_OFS = 4;

  typedef struct packed {
    logic [ADDR_W-1:0] src;
    logic [ADDR_W-1:0] dst;
    logic [CNT_W-1:0]  cnt;
    logic              ien;
  } desc_t;
endpackage

// File: rtl/sgdma_rr.sv
module sgdma_rr #(
  parameter int NCH = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   adv,
  output logic [$clog2(NCH)-1:0] ptr
);
  localparam int CHW = $clog2(NCH);

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (adv) ptr <= (ptr == CHW'(NCH - 1)) ? '0 : ptr + 1'b1;
  end
endmodule

// File: rtl/sgdma_fetch.sv
module sgdma_fetch
  import sgdma_pkg::*;
#(
  parameter int PW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [PW-1:0]     base,
  input  logic              snoop_we,
  input  logic [PW-1:0]     snoop_addr,
  input  logic [PW-1:0]     snoop_data,
  output logic              rd_en,
  output logic [PW-1:0]     rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              done,
  output desc_t             desc,
  output logic [PW-1:0]     link
);
  logic [2:0]        nissue, ncap;
  logic              dv, ovr;
  logic [PW-1:0]     base_q, ovr_val, cur_base;
  logic [DATA_W-1:0] fld [NFIELD-1];
  logic              snoop_hit;

  // a tail patch aimed at the descriptor in flight replaces its link
  assign cur_base  = start ? base : base_q;
  assign snoop_hit = (busy || start) && snoop_we && (snoop_addr == cur_base);
  assign done      = busy && dv && (ncap == 3'(NFIELD - 1));
  assign link      = snoop_hit ? snoop_data : (ovr ? ovr_val : rd_data[PW-1:0]);

  assign desc.src = fld[0][ADDR_W-1:0];
  assign desc.dst = fld[1][ADDR_W-1:0];
  assign desc.cnt = fld[2][CNT_W-1:0];
  assign desc.ien = fld[3][0];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      rd_en   <= 1'b0;
      rd_addr <= '0;
      dv      <= 1'b0;
      nissue  <= '0;
      ncap    <= '0;
      ovr     <= 1'b0;
      ovr_val <= '0;
      base_q  <= '0;
      for (int i = 0; i < NFIELD - 1; i++) fld[i] <= '0;
    end else begin
      dv <= rd_en;
      if (start) begin
        busy    <= 1'b1;
        base_q  <= base;
        rd_en   <= 1'b1;
        rd_addr <= base;
        nissue  <= 3'd1;
        ncap    <= '0;
        ovr     <= snoop_hit;
        ovr_val <= snoop_data;
      end else if (busy) begin
        if (nissue < 3'(NFIELD)) begin
          rd_en   <= 1'b1;
          rd_addr <= rd_addr + 1'b1;
          nissue  <= nissue + 1'b1;
        end else begin
          rd_en <= 1'b0;
        end
        if (dv) begin
          if (ncap < 3'(NFIELD - 1)) fld[ncap[1:0]] <= rd_data;
          ncap <= ncap + 1'b1;
        end
        if (done) busy <= 1'b0;
        if (snoop_hit) begin
          ovr     <= 1'b1;
          ovr_val <= snoop_data;
        end
      end
    end
  end
endmodule

// File: rtl/sgdma_engine.sv
module sgdma_engine
  import sgdma_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int PW    = 16,
  parameter int CW    = 4,
  parameter int BURST = 2048
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   app_valid,
  input  logic [$clog2(NCH)-1:0] app_chan,
  input  logic [PW-1:0]          app_desc,
  input  logic [PW-1:0]          app_last,
  input  logic                   cfg_valid,
  input  logic [$clog2(NCH)-1:0] cfg_chan,
  input  logic [CW-1:0]          cfg_fail,
  input  logic [CW-1:0]          cfg_miss,
  output logic                   mem_rd_en,
  output logic [PW-1:0]          mem_rd_addr,
  input  logic [DATA_W-1:0]      mem_rd_data,
  output logic                   mem_wr_en,
  output logic [PW-1:0]          mem_wr_addr,
  output logic [DATA_W-1:0]      mem_wr_data,
  output logic                   bst_valid,
  output logic [$clog2(NCH)-1:0] bst_chan,
  output logic [ADDR_W-1:0]      bst_src,
  output logic [ADDR_W-1:0]      bst_dst,
  output logic [CNT_W-1:0]       bst_len,
  output logic [NCH-1:0]         done_irq,
  output logic [NCH-1:0]         err_irq,
  output logic [NCH-1:0]         run_o
);
  localparam int CHW = $clog2(NCH);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(BURST);

  // per-channel working registers
  logic [ADDR_W-1:0] src_r  [NCH];
  logic [ADDR_W-1:0] dst_r  [NCH];
  logic [CNT_W-1:0]  cnt_r  [NCH];
  logic [PW-1:0]     nxt_r  [NCH];
  logic [CW-1:0]     fail_r [NCH];
  logic [CW-1:0]     miss_r [NCH];
  logic [NCH-1:0]    ien_r, ld_r;
  logic [CHW-1:0]    fchan;

  logic [CHW-1:0] vp;
  logic           fbusy, fdone, fstart, adv;
  desc_t          fdesc;
  logic [PW-1:0]  flink;

  logic visit, v_run, v_expire, v_norm, v_zero, v_burst, v_need, v_fetch, v_end;
  logic app_here, snoop_we;
  logic [CNT_W-1:0] step;

  always_comb begin
    visit    = !fbusy;
    v_run    = visit && run_o[vp];
    v_expire = v_run && (fail_r[vp] == CW'(1));
    v_norm   = v_run && !v_expire;
    v_zero   = v_norm && ld_r[vp] && (cnt_r[vp] == '0);
    v_burst  = v_norm && ld_r[vp] && (cnt_r[vp] != '0);
    v_need   = v_norm && (!ld_r[vp] || (cnt_r[vp] == '0));
    v_fetch  = v_need && (nxt_r[vp] != '0);
    v_end    = v_need && (nxt_r[vp] == '0);
    app_here = app_valid && (app_chan == vp);
    step     = (cnt_r[vp] > CAP) ? CAP : cnt_r[vp];
  end

  assign fstart   = v_fetch;
  assign adv      = (visit && !v_fetch) || fdone;
  assign snoop_we = app_valid && run_o[app_chan] && (nxt_r[app_chan] != '0);

  sgdma_rr #(.NCH(NCH)) rr_i (.clk(clk), .rst(rst), .adv(adv), .ptr(vp));

  sgdma_fetch #(.PW(PW)) fetch_i (
    .clk(clk), .rst(rst), .start(fstart), .base(nxt_r[vp]),
    .snoop_we(snoop_we), .snoop_addr(app_last), .snoop_data(app_desc),
    .rd_en(mem_rd_en), .rd_addr(mem_rd_addr), .rd_data(mem_rd_data),
    .busy(fbusy), .done(fdone), .desc(fdesc), .link(flink)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_o <= '0; ld_r <= '0; ien_r <= '0; fchan <= '0;
      done_irq <= '0; err_irq <= '0; bst_valid <= 1'b0; mem_wr_en <= 1'b0;
      bst_chan <= '0; bst_src <= '0; bst_dst <= '0; bst_len <= '0;
      mem_wr_addr <= '0; mem_wr_data <= '0;
      for (int c = 0; c < NCH; c++) begin
        src_r[c] <= '0; dst_r[c] <= '0; cnt_r[c] <= '0;
        nxt_r[c] <= '0; fail_r[c] <= '0; miss_r[c] <= '0;
      end
    end else begin
      done_irq  <= '0;
      err_irq   <= '0;
      bst_valid <= 1'b0;
      mem_wr_en <= 1'b0;
      // visit of the rotating channel
      if (v_run) begin
        if (fail_r[vp] != '0) fail_r[vp] <= fail_r[vp] - 1'b1;
        if (v_expire) begin
          run_o[vp]   <= 1'b0;
          err_irq[vp] <= 1'b1;
        end
        if (v_burst) begin
          bst_valid <= 1'b1;
          bst_chan  <= vp;
          bst_src   <= src_r[vp];
          bst_dst   <= dst_r[vp];
          bst_len   <= step;
          cnt_r[vp] <= cnt_r[vp] - step;
          src_r[vp] <= src_r[vp] + ADDR_W'(step);
          dst_r[vp] <= dst_r[vp] + ADDR_W'(step);
        end
        if (v_zero) begin
          ld_r[vp] <= 1'b0;
          if (ien_r[vp]) begin
            if (miss_r[vp] != '0) miss_r[vp] <= miss_r[vp] - 1'b1;
            else done_irq[vp] <= 1'b1;
          end
        end
        if (v_fetch) fchan <= vp;
        if (v_end && !app_here) run_o[vp] <= 1'b0;
      end
      // fetched descriptor lands in the working registers
      if (fdone) begin
        src_r[fchan] <= fdesc.src;
        dst_r[fchan] <= fdesc.dst;
        cnt_r[fchan] <= fdesc.cnt;
        ien_r[fchan] <= fdesc.ien;
        nxt_r[fchan] <= flink;
        ld_r[fchan]  <= 1'b1;
      end
      // host append: start, pending link or tail patch
      if (app_valid) begin
        if (!run_o[app_chan]) begin
          nxt_r[app_chan] <= app_desc;
          run_o[app_chan] <= 1'b1;
          ld_r[app_chan]  <= 1'b0;
        end else if (nxt_r[app_chan] == '0) begin
          nxt_r[app_chan] <= app_desc;
        end else begin
          mem_wr_en   <= 1'b1;
          mem_wr_addr <= app_last + PW'(LINK_OFS);
          mem_wr_data <= DATA_W'(app_desc);
        end
      end
      if (cfg_valid && !run_o[cfg_chan]) begin
        fail_r[cfg_chan] <= cfg_fail;
        miss_r[cfg_chan] <= cfg_miss;
      end
    end
  end
endmodule

// File: rtl/sgdma_engine_chk.sv
module sgdma_engine_chk #(
  parameter int NCH   = 4,
  parameter int PW    = 16,
  parameter int BURST = 2048
) (
  input logic           clk,
  input logic           rst,
  input logic           mem_rd_en,
  input logic [PW-1:0]  mem_rd_addr,
  input logic           bst_valid,
  input logic [15:0]    bst_len,
  input logic [NCH-1:0] done_irq,
  input logic [NCH-1:0] err_irq,
  input logic [NCH-1:0] run_o
);
  logic [3:0] rd_run;

  always_ff @(posedge clk) begin
    if (rst) rd_run <= '0;
    else if (mem_rd_en) rd_run <= (rd_run == 4'hF) ? rd_run : rd_run + 1'b1;
    else rd_run <= '0;
  end

  a_r4_burst_cap: assert property (@(posedge clk) disable iff (rst)
    bst_valid |-> (bst_len != 16'd0) && (32'(bst_len) <= BURST));

  a_r3_reads_consecutive: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en && $past(mem_rd_en)) |-> (mem_rd_addr == $past(mem_rd_addr) + 1'b1));

  a_r3_five_reads: assert property (@(posedge clk) disable iff (rst)
    rd_run <= 4'd5);

  a_r11_single_pulse: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done_irq, err_irq}));

  a_r11_burst_alone: assert property (@(posedge clk) disable iff (rst)
    bst_valid |-> ((done_irq | err_irq) == '0));

  a_r9_err_halts: assert property (@(posedge clk) disable iff (rst)
    (err_irq != '0) |-> ((err_irq & run_o) == '0));
endmodule

bind sgdma_engine sgdma_engine_chk #(.NCH(NCH), .PW(PW), .BURST(BURST)) chk_i (
  .clk(clk), .rst(rst), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
  .bst_valid(bst_valid), .bst_len(bst_len), .done_irq(done_irq),
  .err_irq(err_irq), .run_o(run_o)
);

// File: tb/sgdma_engine_tb_top.sv
module sgdma_engine_tb_top;
  localparam int NCH = 4;
  localparam int PW  = 16;
  localparam int CW  = 4;
  localparam int BURST = 2048;
  localparam logic [31:0] OFF = 32'h0001_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic           app_valid = 0, cfg_valid = 0;
  logic [1:0]     app_chan = 0, cfg_chan = 0;
  logic [PW-1:0]  app_desc = 0, app_last = 0;
  logic [CW-1:0]  cfg_fail = 0, cfg_miss = 0;
  logic           mem_rd_en, mem_wr_en, bst_valid;
  logic [PW-1:0]  mem_rd_addr, mem_wr_addr;
  logic [31:0]    mem_rd_data, mem_wr_data, bst_src, bst_dst;
  logic [1:0]     bst_chan;
  logic [15:0]    bst_len;
  logic [NCH-1:0] done_irq, err_irq, run_o;

  sgdma_engine #(.NCH(NCH), .PW(PW), .CW(CW), .BURST(BURST)) dut_i (.*);

  logic [31:0] mem [256];
  always @(posedge clk) begin
    if (mem_wr_en) mem[mem_wr_addr[7:0]] <= mem_wr_data;
    if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[7:0]];
  end

  int nchk = 0, nfail = 0, cyc = 0;
  int bytes [NCH], nb [NCH], ndone [NCH], nerr [NCH], lastb [NCH];

  task automatic chk(input string tag, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_stats();
    for (int c = 0; c < NCH; c++) begin
      bytes[c] = 0; nb[c] = 0; ndone[c] = 0; nerr[c] = 0; lastb[c] = -100;
    end
  endtask

  // burst and pulse monitor
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (bst_valid) begin
        bytes[bst_chan] += int'(bst_len);
        nb[bst_chan]++;
        if (bst_dst != bst_src + OFF) chk("R4 burst address pair", bst_dst, bst_src + OFF);
        if (cyc - lastb[bst_chan] < NCH) chk("R11 burst spacing", cyc - lastb[bst_chan], NCH);
        lastb[bst_chan] = cyc;
      end
      for (int c = 0; c < NCH; c++) begin
        if (done_irq[c]) ndone[c]++;
        if (err_irq[c]) nerr[c]++;
      end
    end
  end

  task automatic put_desc(input int p, input int src, input int cnt, input bit ien, input int lnk);
    mem[p] = src; mem[p+1] = src + OFF; mem[p+2] = cnt; mem[p+3] = {31'd0, ien}; mem[p+4] = lnk;
  endtask

  task automatic append(input int ch, input int d, input int last);
    @(negedge clk);
    app_valid = 1; app_chan = 2'(ch); app_desc = PW'(d); app_last = PW'(last);
    @(negedge clk);
    app_valid = 0;
  endtask

  task automatic set_cnt(input int ch, input int f, input int m);
    @(negedge clk);
    cfg_valid = 1; cfg_chan = 2'(ch); cfg_fail = CW'(f); cfg_miss = CW'(m);
    @(negedge clk);
    cfg_valid = 0;
  endtask

  task automatic wait_idle(input logic [NCH-1:0] mask);
    int n = 0;
    @(negedge clk);
    while ((run_o & mask) != 0 && n < 20000) begin @(negedge clk); n++; end
    chk("R6 channel stops at end of chain", int'((run_o & mask) != 0), 0);
    repeat (2) @(negedge clk);
  endtask

  function automatic int nbursts(input int cnt);
    return (cnt + BURST - 1) / BURST;
  endfunction

  function automatic int sweep_cnt(input int i);
    case (i)
      0: return 0;       1: return 1;      2: return 2047;  3: return 2048;
      4: return 2049;    5: return 4096;   6: return 13000; default: return 65535;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 0;
    clear_stats();
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    chk("R1 run after reset", run_o, 0);
    chk("R1 no burst/pulse/mem after reset",
        {bst_valid, done_irq, err_irq, mem_rd_en, mem_wr_en}, 0);

    // R2, R3, R4, R5: single descriptor
    put_desc(16, 32'h1000, 32'h1A00, 1, 0);
    append(0, 16, 0);
    chk("R2 run set after append", run_o[0], 1);
    begin
      int n = 0;
      while (!mem_rd_en && n < 50) begin @(negedge clk); n++; end
      for (int k = 0; k < 5; k++) begin
        chk("R3 fetch read strobe", mem_rd_en, 1);
        chk("R3 fetch read address", mem_rd_addr, 16 + k);
        @(negedge clk);
      end
    end
    wait_idle(4'b0001);
    chk("R4 bytes single", bytes[0], 32'h1A00);
    chk("R4 burst count single", nb[0], 4);
    chk("R5 completion with ien", ndone[0], 1);

    // R4 sweep of counts, R5 ien clear gives no pulse
    for (int i = 0; i < 8; i++) begin
      clear_stats();
      put_desc(24, 32'h2000, sweep_cnt(i), 0, 0);
      append(1, 24, 0);
      wait_idle(4'b0010);
      chk("R4 sweep bytes", bytes[1], sweep_cnt(i));
      chk("R4 sweep bursts", nb[1], nbursts(sweep_cnt(i)));
      chk("R5 no pulse with ien clear", ndone[1], 0);
    end

    // R6 chain of three, zero-count middle, ien only on tail
    clear_stats();
    put_desc(32, 32'h3000, 32'h900, 0, 48);
    put_desc(48, 32'h4000, 0, 0, 64);
    put_desc(64, 32'h5000, 32'h300, 1, 0);
    append(2, 32, 0);
    wait_idle(4'b0100);
    chk("R6 chain bytes", bytes[2], 32'hC00);
    chk("R6 chain bursts", nb[2], 3);
    chk("R5 chain pulses", ndone[2], 1);

    // R5 miss counter
    clear_stats();
    set_cnt(3, 0, 2);
    put_desc(80, 32'h100, 16, 1, 96);
    put_desc(96, 32'h200, 16, 1, 112);
    put_desc(112, 32'h300, 16, 1, 0);
    append(3, 80, 0);
    wait_idle(4'b1000);
    chk("R5 miss suppresses two of three", ndone[3], 1);
    chk("R5 miss chain bytes", bytes[3], 48);
    clear_stats();
    append(3, 112, 0);
    wait_idle(4'b1000);
    chk("R5 miss counter exhausted", ndone[3], 1);

    // R9 fail countdown
    clear_stats();
    set_cnt(3, 1, 0);
    put_desc(128, 32'h6000, 32'h1000, 1, 0);
    append(3, 128, 0);
    wait_idle(4'b1000);
    chk("R9 fail=1 error pulse", nerr[3], 1);
    chk("R9 fail=1 no bytes", bytes[3], 0);
    chk("R9 fail=1 no completion", ndone[3], 0);
    clear_stats();
    set_cnt(3, 3, 0);
    append(3, 128, 0);
    wait_idle(4'b1000);
    chk("R9 fail=3 error pulse", nerr[3], 1);
    chk("R9 fail=3 one burst moved", bytes[3], 32'h800);

    // R10 counters ignored while running
    clear_stats();
    put_desc(144, 32'h7000, 32'h4000, 1, 0);
    append(0, 144, 0);
    set_cnt(0, 1, 1);
    wait_idle(4'b0001);
    chk("R10 no error after ignored write", nerr[0], 0);
    chk("R10 pulse not suppressed", ndone[0], 1);
    chk("R10 full transfer", bytes[0], 32'h4000);

    // R7 append to running channel: pending link, then tail patch
    clear_stats();
    put_desc(160, 32'h8000, 32'h4000, 1, 0);
    put_desc(176, 32'h9000, 32'h100, 1, 0);
    put_desc(192, 32'hA000, 32'h200, 1, 0);
    append(1, 160, 0);
    begin
      int n = 0;
      while (nb[1] < 1 && n < 100) begin @(negedge clk); n++; end
    end
    append(1, 176, 160);
    append(1, 192, 176);
    wait_idle(4'b0010);
    chk("R7 tail link patched in memory", mem[180], 192);
    chk("R7 appended bytes", bytes[1], 32'h4300);
    chk("R7 appended pulses", ndone[1], 3);

    // R8 and R12: sweep append timing against a short chain
    for (int d = 0; d < 24; d++) begin
      clear_stats();
      put_desc(208, 32'hB000, 0, 1, 0);
      put_desc(224, 32'hC000, 32'h40, 1, 0);
      append(2, 208, 0);
      repeat (d) @(negedge clk);
      append(2, 224, 208);
      wait_idle(4'b0100);
      chk("R8 R12 appended descriptor moved", bytes[2], 32'h40);
      chk("R8 R12 both completions", ndone[2], 2);
    end

    // R11 all channels together
    clear_stats();
    for (int c = 0; c < NCH; c++) put_desc(16 + 16 * c, 32'h10000 * (c + 1), 32'h1000 + 32'h800 * c, 1, 0);
    for (int c = 0; c < NCH; c++) append(c, 16 + 16 * c, 0);
    wait_idle(4'b1111);
    for (int c = 0; c < NCH; c++) begin
      chk("R11 concurrent bytes", bytes[c], 32'h1000 + 32'h800 * c);
      chk("R11 concurrent pulse", ndone[c], 1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule